// File: doc/BRIEF.md
# USB Link Power Management Responder

This block sits beside the packet layer of a USB device controller and decides how the device answers a link power management (LPM) token. Software programs a one-byte control register. It holds a two-bit support level, a request to enter the L1 sleep state, a bit that forces NAK while asleep, and a bit that starts a hardware-timed remote-wake pulse. When the packet layer reports a decoded LPM token, the block registers a handshake code one cycle later. The code is none, STALL, NYET or ACK. The choice depends on the support level, the sleep request and whether every transmit FIFO is empty.

When the block answers ACK it enters L1, clears the sleep request and pulses an interrupt. When it answers NYET to a pending request it also pulses the interrupt, but the request stays set. Each interrupt pulse sets a sticky flag, which software clears with a strobe. While NAK forcing is armed by a sleep entry, the block tells the endpoints to NAK every non-LPM transaction. A resume from either side takes the block out of L1. The resume may come from the host or be started by software through the wake bit, whose pulse lasts a parameterised number of cycles.

Top module: `lpm_responder`

## Requirements
- R1: With the support level (register bits [1:0]) at 00 or 01, an LPM token produces no handshake: `hs_valid_o` stays 0.
- R2: With support level 10, every LPM token produces `hs_valid_o` = 1 with `hs_code_o` = 1 (STALL) in the cycle after the token.
- R3: With support level 11 and the sleep request (bit 2) clear, a token is answered with code 2 (NYET). No interrupt is raised and `l1_o` stays 0.
- R4: With support level 11, the sleep request set and every bit of `tx_fifo_empty_i` high, a token is answered with code 3 (ACK). In the same cycle the request bit reads 0, `l1_o` is 1 and `irq_o` pulses.
- R5: With support level 11, the sleep request set and any FIFO not empty, a token is answered with NYET, `irq_o` pulses and the request bit stays 1.
- R6: The sleep request has no effect unless the support level is 11. With level 10 and the request set, a token still gets STALL, no interrupt and the request stays 1. Level and request may be written in the same register write.
- R7: `force_nak_o` is 1 only while the NAK bit (bit 3) is 1 and the block has entered L1 since the bit was last clear. It stays 1 after a resume until software clears the bit.
- R8: Writing 1 to the wake bit (bit 4) drives `resume_o` high for exactly WAKE_CYC cycles, starting the cycle after the write. Bit 4 reads 1 during the pulse and 0 after it.
- R9: A host resume strobe or the start of a software wake clears `l1_o` after the next clock edge.
- R10: `irq_o` lasts one cycle per answered request. Each pulse sets `irq_flag_o`, which stays set until `irq_clr_i` is strobed.
- R11: After reset all control bits, `l1_o`, `resume_o`, `force_nak_o` and `irq_flag_o` are 0. Register bits [7:5] read 0 even after being written 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 8 | Control register write data |
| cfg_rd_data | output | 8 | Control register read value |
| irq_clr_i | input | 1 | Clears the sticky interrupt flag |
| lpm_tok_i | input | 1 | Decoded LPM token strobe from the packet layer |
| tx_fifo_empty_i | input | N_TXFIFO | Empty flag of each transmit FIFO |
| host_resume_i | input | 1 | Host-initiated resume detected |
| hs_valid_o | output | 1 | Handshake code valid for one cycle |
| hs_code_o | output | 2 | Handshake: 0 none, 1 STALL, 2 NYET, 3 ACK |
| l1_o | output | 1 | Link is in L1 sleep |
| force_nak_o | output | 1 | Endpoints must NAK non-LPM transactions |
| resume_o | output | 1 | Remote-wake signalling active |
| irq_o | output | 1 | One-cycle interrupt pulse |
| irq_flag_o | output | 1 | Sticky interrupt status |

## Verification
Each handshake is checked one cycle after its token. The request bit, `l1_o` and the interrupt flag are read back in that same cycle, so a wrong decision or a missed self-clear shows up at once. A lost or stray handshake is caught by the scoreboard as a missing or unexpected item. A wrong armed state for NAK forcing shows on `force_nak_o` at the next sample after a sleep entry, a resume or a register write. A miscounted wake timer shows as a `resume_o` pulse of the wrong length.

// File: rtl/lpm_pkg.sv
// Shared types for the LPM responder: handshake codes and register field positions.
package lpm_pkg;
    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_STALL = 2'd1,
        HS_NYET  = 2'd2,
        HS_ACK   = 2'd3
    } hs_e;

    localparam int unsigned REG_W    = 8;
    localparam int unsigned F_LVL_LO = 0;
    localparam int unsigned F_REQ    = 2;
    localparam int unsigned F_NAK    = 3;
    localparam int unsigned F_WAKE   = 4;
    localparam int unsigned F_RSV_LO = 5;
endpackage

// File: rtl/lpm_ctrl_reg.sv
// Control register for the LPM responder.
// Holds the support level, sleep request and NAK bit, and decodes a wake start.
// Assumes a wake write arriving while a pulse is running is ignored.
// The handshake logic can clear the request bit, but a software write in
// the same cycle has priority over that clear.
module lpm_ctrl_reg
    import lpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             req_clr,
    input  logic             wake_busy,
    output logic [1:0]       lvl,
    output logic             req,
    output logic             nak,
    output logic             wake_start,
    output logic [REG_W-1:0] rd_data
);
    logic unused_rsvd;

    // Reserved bits are accepted on the bus and dropped.
    assign unused_rsvd = ^wr_data[REG_W-1:F_RSV_LO];

    // Store the writable fields; self-clear the request on an ACK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl <= 2'b00;
            req <= 1'b0;
            nak <= 1'b0;
        end else if (wr_en) begin
            lvl <= wr_data[F_LVL_LO +: 2];
            req <= wr_data[F_REQ];
            nak <= wr_data[F_NAK];
        end else if (req_clr) begin
            req <= 1'b0;
        end
    end

    // A wake starts on a write of 1 while no pulse is running.
    assign wake_start = wr_en && wr_data[F_WAKE] && !wake_busy;

    // Read value: reserved bits are 0, the wake bit shows that a pulse is running.
    always_comb begin
        rd_data                   = '0;
        rd_data[F_LVL_LO +: 2]    = lvl;
        rd_data[F_REQ]            = req;
        rd_data[F_NAK]            = nak;
        rd_data[F_WAKE]           = wake_busy;
    end
endmodule

// File: rtl/lpm_wake_timer.sv
// Hardware-timed remote-wake pulse.
// When started, the pulse stays high for exactly WAKE_CYC cycles.
// Assumes WAKE_CYC >= 1 and that start is ignored while busy.
module lpm_wake_timer #(
    parameter int unsigned WAKE_CYC = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int unsigned CW = $clog2(WAKE_CYC + 1);

    logic [CW-1:0] remain;

    // Load on start, count down while busy, drop busy at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                remain <= CW'(WAKE_CYC - 1);
            end
        end else if (remain == '0) begin
            busy <= 1'b0;
        end else begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/lpm_hs_decide.sv
// Combinational handshake choice for a decoded LPM token.
// Assumes the caller registers the result. Levels 00 and 01 give no handshake,
// 10 gives STALL, and 11 gives ACK or NYET depending on the request and FIFO state.
module lpm_hs_decide
    import lpm_pkg::*;
#(
    parameter int unsigned N_TXFIFO = 4
) (
    input  logic                tok,
    input  logic [1:0]          lvl,
    input  logic                req,
    input  logic [N_TXFIFO-1:0] fifo_empty,
    output hs_e                 code,
    output logic                irq_req,
    output logic                go_l1
);
    logic all_empty;

    // Data is pending if any FIFO reports non-empty.
    assign all_empty = &fifo_empty;

    // Pick the handshake and its side effects.
    always_comb begin
        code    = HS_NONE;
        irq_req = 1'b0;
        go_l1   = 1'b0;
        if (tok) begin
            unique case (lvl)
                2'b10:   code = HS_STALL;
                2'b11: begin
                    if (req && all_empty) begin
                        code    = HS_ACK;
                        irq_req = 1'b1;
                        go_l1   = 1'b1;
                    end else begin
                        code    = HS_NYET;
                        irq_req = req;
                    end
                end
                default: code = HS_NONE;
            endcase
        end
    end
endmodule

// File: rtl/lpm_responder.sv
// LPM responder top level.
// Registers the handshake, tracks L1, arms NAK forcing, and drives the interrupt
// pulse and its sticky flag. Assumes lpm_tok_i and host_resume_i are
// single-cycle strobes already synchronised to clk.
module lpm_responder
    import lpm_pkg::*;
#(
    parameter int unsigned N_TXFIFO = 4,
    parameter int unsigned WAKE_CYC = 3000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [7:0]          cfg_wr_data,
    output logic [7:0]          cfg_rd_data,
    input  logic                irq_clr_i,
    input  logic                lpm_tok_i,
    input  logic [N_TXFIFO-1:0] tx_fifo_empty_i,
    input  logic                host_resume_i,
    output logic                hs_valid_o,
    output logic [1:0]          hs_code_o,
    output logic                l1_o,
    output logic                force_nak_o,
    output logic                resume_o,
    output logic                irq_o,
    output logic                irq_flag_o
);
    logic [1:0] lvl;
    logic       req, nak, wake_start, wake_busy;
    hs_e        code_d;
    logic       irq_d, go_l1_d, armed;

    lpm_ctrl_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_data    (cfg_wr_data),
        .req_clr    (go_l1_d),
        .wake_busy  (wake_busy),
        .lvl        (lvl),
        .req        (req),
        .nak        (nak),
        .wake_start (wake_start),
        .rd_data    (cfg_rd_data)
    );

    lpm_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wake_start),
        .busy  (wake_busy)
    );

    lpm_hs_decide #(.N_TXFIFO(N_TXFIFO)) u_dec (
        .tok        (lpm_tok_i),
        .lvl        (lvl),
        .req        (req),
        .fifo_empty (tx_fifo_empty_i),
        .code       (code_d),
        .irq_req    (irq_d),
        .go_l1      (go_l1_d)
    );

    // Register the handshake and the interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_valid_o <= 1'b0;
            hs_code_o  <= HS_NONE;
            irq_o      <= 1'b0;
        end else begin
            hs_valid_o <= (code_d != HS_NONE);
            hs_code_o  <= code_d;
            irq_o      <= irq_d;
        end
    end

    // Sticky interrupt flag: a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          irq_flag_o <= 1'b0;
        else if (irq_d)      irq_flag_o <= 1'b1;
        else if (irq_clr_i)  irq_flag_o <= 1'b0;
    end

    // L1 state: any resume exits, an ACK enters.
    always_ff @(posedge clk) begin
        if (!rst_n)                           l1_o <= 1'b0;
        else if (host_resume_i || wake_start) l1_o <= 1'b0;
        else if (go_l1_d)                     l1_o <= 1'b1;
    end

    // NAK arming: set on L1 entry, dropped once the NAK bit is clear outside L1.
    always_ff @(posedge clk) begin
        if (!rst_n)             armed <= 1'b0;
        else if (go_l1_d)       armed <= 1'b1;
        else if (!nak && !l1_o) armed <= 1'b0;
    end

    assign force_nak_o = nak && (armed || l1_o);
    assign resume_o    = wake_busy;
endmodule

// File: rtl/lpm_responder_chk.sv
// Property checker for lpm_responder, attached through bind.
// Only reads the ports of the top module.
module lpm_responder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_rd_data,
    input logic       hs_valid_o,
    input logic [1:0] hs_code_o,
    input logic       l1_o,
    input logic       force_nak_o,
    input logic       resume_o,
    input logic       irq_o,
    input logic       irq_flag_o,
    input logic       host_resume_i
);
    // R1: any handshake requires support level bit 1 set one cycle earlier.
    p_silent_low_lvl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid_o |-> $past(cfg_rd_data[1]));

    // R2: STALL only comes from level 10.
    p_stall_lvl10_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid_o && hs_code_o == 2'd1) |-> $past(cfg_rd_data[1:0]) == 2'b10);

    // R4: an ACK comes with a cleared request and entry into L1.
    p_ack_enters_l1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid_o && hs_code_o == 2'd3) |-> (!cfg_rd_data[2] && l1_o));

    // R5: a NYET that raises an interrupt keeps the request.
    p_nyet_keeps_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid_o && hs_code_o == 2'd2 && irq_o) |-> cfg_rd_data[2]);

    // R7: NAK forcing needs the NAK bit.
    p_nak_needs_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        force_nak_o |-> cfg_rd_data[3]);

    // R8: the wake bit mirrors the resume pulse.
    p_wake_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o == cfg_rd_data[4]);

    // R9: a host resume leaves L1.
    p_host_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_resume_i |=> !l1_o);

    // R9: a started wake pulse leaves L1.
    p_wake_exits_l1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume_o) |-> !l1_o);

    // R10: an interrupt pulse comes with NYET or ACK and sets the flag.
    p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (hs_valid_o && hs_code_o[1] && irq_flag_o));
endmodule

bind lpm_responder lpm_responder_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_rd_data   (cfg_rd_data),
    .hs_valid_o    (hs_valid_o),
    .hs_code_o     (hs_code_o),
    .l1_o          (l1_o),
    .force_nak_o   (force_nak_o),
    .resume_o      (resume_o),
    .irq_o         (irq_o),
    .irq_flag_o    (irq_flag_o),
    .host_resume_i (host_resume_i)
);

// File: tb/sim_lpm_responder.sv
`timescale 1ns/1ps
module sim_lpm_responder;
    localparam int NF = 4;
    localparam int WC = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [7:0]    cfg_wr_data = '0;
    logic [7:0]    cfg_rd_data;
    logic          irq_clr_i = 1'b0;
    logic          lpm_tok_i = 1'b0;
    logic [NF-1:0] tx_fifo_empty_i = '1;
    logic          host_resume_i = 1'b0;
    logic          hs_valid_o, l1_o, force_nak_o, resume_o, irq_o, irq_flag_o;
    logic [1:0]    hs_code_o;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;
    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    lpm_responder #(.N_TXFIFO(NF), .WAKE_CYC(WC)) u0 (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_data = d;
        @(negedge clk); cfg_wr_en = 1'b0;
    endtask

    // Driver: push the expected handshake, then pulse the token.
    task automatic token(input bit some, input logic [1:0] code, input string tag);
        @(negedge clk);
        if (some) begin exp_q.push_back(code); tag_q.push_back(tag); end
        lpm_tok_i = 1'b1;
        @(negedge clk);
        lpm_tok_i = 1'b0;
    endtask

    // Monitor: pop and compare every handshake the design produces.
    always @(negedge clk) begin
        if (rst_n && hs_valid_o) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R1: actual handshake %0d expected none", hs_code_o);
            end else begin
                chk(tag_q.pop_front(), int'(hs_code_o), int'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", cfg_rd_data, 0);
        chk("R11", l1_o, 0);
        chk("R11", resume_o, 0);
        chk("R11", force_nak_o, 0);
        chk("R11", irq_flag_o, 0);
        wr(8'hE0);
        chk("R11", cfg_rd_data, 0);

        // R1 levels 00 and 01: silent
        token(0, 2'd0, "R1");
        wr(8'h01);
        token(0, 2'd0, "R1");
        @(negedge clk);
        chk("R1", exp_q.size(), 0);

        // R2 level 10: STALL
        wr(8'h02);
        token(1, 2'd1, "R2");
        // R6 request ignored at level 10
        wr(8'h06);
        token(1, 2'd1, "R6");
        chk("R6", cfg_rd_data, 8'h06);
        chk("R6", irq_flag_o, 0);

        // R3 level 11, no request: NYET, no interrupt, awake
        wr(8'h03);
        token(1, 2'd2, "R3");
        chk("R3", irq_o, 0);
        chk("R3", l1_o, 0);

        // R5 request with data pending: NYET, interrupt, request kept
        tx_fifo_empty_i = 4'b1011;
        wr(8'h07);
        token(1, 2'd2, "R5");
        chk("R5", irq_o, 1);
        chk("R5", cfg_rd_data[2], 1);
        chk("R5", l1_o, 0);
        @(negedge clk); irq_clr_i = 1'b1;
        @(negedge clk); irq_clr_i = 1'b0;
        chk("R10", irq_flag_o, 0);

        // R4 all FIFOs empty, NAK bit set: ACK, L1, request cleared
        tx_fifo_empty_i = '1;
        wr(8'h0F);
        token(1, 2'd3, "R4");
        chk("R4", cfg_rd_data, 8'h0B);
        chk("R4", l1_o, 1);
        chk("R4", irq_o, 1);
        chk("R7", force_nak_o, 1);
        @(negedge clk);
        chk("R10", irq_o, 0);
        chk("R10", irq_flag_o, 1);
        irq_clr_i = 1'b1;
        @(negedge clk); irq_clr_i = 1'b0;
        chk("R10", irq_flag_o, 0);

        // R9 host resume leaves L1; R7 forcing survives until the bit clears
        host_resume_i = 1'b1;
        @(negedge clk); host_resume_i = 1'b0;
        chk("R9", l1_o, 0);
        chk("R7", force_nak_o, 1);
        wr(8'h03);
        chk("R7", force_nak_o, 0);

        // R7 sleep with NAK bit clear: no forcing
        wr(8'h07);
        token(1, 2'd3, "R4");
        chk("R7", force_nak_o, 0);
        chk("R4", l1_o, 1);

        // R8 wake pulse length; R9 wake leaves L1
        wr(8'h13);
        chk("R9", l1_o, 0);
        chk("R8", cfg_rd_data[4], 1);
        begin
            int len = 0;
            while (resume_o && len < 200) begin
                len++;
                @(negedge clk);
            end
            chk("R8", len, WC);
        end
        chk("R8", cfg_rd_data[4], 0);

        repeat (2) @(negedge clk);
        chk("R1", exp_q.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule